// File: doc/BRIEF.md
# Program Counter with Memory Address Source Select

This block keeps the instruction pointer of a small accumulator processor and chooses what appears on the memory address bus. An 8-bit register holds the current count. When the controller raises the update strobe, the register loads a new value. The select input picks that value: a jump target carried in the address field of the instruction register, or the current count plus one. The plus-one path is a chain of AND/XOR half-adder cells, because one operand is the constant 1.

A second select input drives the shared memory address bus. Each of its two bits enables one source: one bit puts the instruction-register address field on the bus, the other puts the counter on it. The block flags whether the bus carries a valid address. It raises an error output when both sources are enabled at once. The controller decides whether a branch is taken and issues the strobes to match.

Top module: `pcAddrTop`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pcValue` becomes 0 after that edge, whatever the other inputs are.
- R2: With `pcEn` high and `nextSel` = 2'b00, `pcValue` after the edge equals the `irAddr` value present before the edge.
- R3: With `pcEn` high and `nextSel` = 2'b01, `pcValue` after the edge equals the previous count plus one, and 8'hFF steps to 8'h00.
- R4: With `pcEn` high and `nextSel` = 2'b10 or 2'b11, `pcValue` keeps its value across the edge.
- R5: With `pcEn` low, `pcValue` keeps its value for every `nextSel` code.
- R6: With `addrSel` = 2'b01 (bit 0 set alone), `memAddr` equals `irAddr` and `addrValid` is 1.
- R7: With `addrSel` = 2'b10 (bit 1 set alone), `memAddr` equals `pcValue` and `addrValid` is 1.
- R8: With `addrSel` = 2'b00, `addrValid` is 0 and `memAddr` is 0.
- R9: With `addrSel` = 2'b11, `addrConflict` is 1, `addrValid` is 0 and `memAddr` is 0.
- R10: `addrConflict` is 0 for every `addrSel` code other than 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| irAddr | input | 8 | Address field of the instruction register |
| nextSel | input | 2 | Next-count source: 00 jump target, 01 count plus one, 10/11 no source |
| pcEn | input | 1 | Update strobe for the count register |
| addrSel | input | 2 | Bus source enables: bit 0 instruction field, bit 1 counter |
| pcValue | output | 8 | Current count |
| memAddr | output | 8 | Memory address bus |
| addrValid | output | 1 | Exactly one bus source is enabled |
| addrConflict | output | 1 | Both bus sources are enabled |

## Verification
The bench first uses directed runs. It jumps to 8'hFE and increments twice, so the 8'hFF-to-0 wrap is separated from an ordinary carry. It then applies both no-source codes with the strobe high, and every select code with the strobe low, which separates holding from loading. The jump target and the counter are given different values while the bench steps through all four bus-select codes, so it can tell which source reached the bus. A pseudo-random run with a mid-run reset then mixes strobes, select codes and addresses on every cycle.

// File: rtl/pcAddrPkg.sv
package pcAddrPkg;

  // next-count source codes
  localparam logic [1:0] NEXT_JUMP = 2'b00;
  localparam logic [1:0] NEXT_INC  = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic loadJump;   // load count from instruction address field
    logic loadInc;    // load count plus one
    logic driveIr;    // instruction field owns the address bus
    logic drivePc;    // counter owns the address bus
    logic busFault;   // both sources requested
  } pcStrobes_t;

endpackage

// File: rtl/pcAddrCtrl.sv
module pcAddrCtrl
  import pcAddrPkg::*;
(
  input  logic [1:0] nextSel,
  input  logic       pcEn,
  input  logic [1:0] addrSel,
  output pcStrobes_t strobes
);

  logic wantIr;
  logic wantPc;

  assign wantIr = addrSel[0];
  assign wantPc = addrSel[1];

  always_comb begin
    strobes          = '0;
    strobes.loadJump = pcEn && (nextSel == NEXT_JUMP);
    strobes.loadInc  = pcEn && (nextSel == NEXT_INC);
    // a clash blocks both drivers instead of letting them fight
    strobes.busFault = wantIr && wantPc;
    strobes.driveIr  = wantIr && !wantPc;
    strobes.drivePc  = wantPc && !wantIr;
  end

  // R4: at most one load path active
  always_comb begin
    p_single_load_r4: assert ($onehot0({strobes.loadJump, strobes.loadInc}));
  end

  // R10: bus ownership states are mutually exclusive
  always_comb begin
    p_single_owner_r10: assert ($onehot0({strobes.driveIr, strobes.drivePc, strobes.busFault}));
  end

endmodule

// File: rtl/pcAddrDatapath.sv
module pcAddrDatapath
  import pcAddrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] irAddr,
  input  pcStrobes_t        strobes,
  output logic [ADDR_W-1:0] pcValue,
  output logic [ADDR_W-1:0] memAddr,
  output logic              addrValid,
  output logic              addrConflict
);

  localparam int CARRY_W = ADDR_W + 1;

  logic [ADDR_W-1:0]  pcQ;
  logic [ADDR_W-1:0]  pcPlusOne;
  logic [CARRY_W-1:0] rippleCarry;
  logic [ADDR_W-1:0]  nextVal;
  logic               loadAny;

  // half-adder chain: constant 1 enters as the first carry
  assign rippleCarry[0] = 1'b1;
  generate
    for (genvar i = 0; i < ADDR_W; i++) begin : g_incCell
      assign pcPlusOne[i]     = pcQ[i] ^ rippleCarry[i];
      assign rippleCarry[i+1] = pcQ[i] & rippleCarry[i];
    end
  endgenerate

  assign loadAny = strobes.loadJump | strobes.loadInc;

  always_comb begin
    nextVal = pcQ;
    if (strobes.loadJump) nextVal = irAddr;
    else if (strobes.loadInc) nextVal = pcPlusOne;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else if (loadAny) pcQ <= nextVal;
  end

  // bus as a wired-OR of gated drivers
  assign memAddr      = ({ADDR_W{strobes.driveIr}} & irAddr)
                      | ({ADDR_W{strobes.drivePc}} & pcQ);
  assign addrValid    = strobes.driveIr | strobes.drivePc;
  assign addrConflict = strobes.busFault;
  assign pcValue      = pcQ;

  // R2: jump loads the target
  p_jump_load_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.loadJump |=> pcQ == $past(irAddr));

  // R3: increment steps by one with wrap
  p_inc_step_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.loadInc |=> pcQ == ADDR_W'($past(pcQ) + 1'b1));

  // R5: no load strobe, no change
  p_no_load_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(strobes.loadJump || strobes.loadInc) |=> $stable(pcQ));

endmodule

// File: rtl/pcAddrTop.sv
module pcAddrTop
  import pcAddrPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] irAddr,
  input  logic [1:0] nextSel,
  input  logic       pcEn,
  input  logic [1:0] addrSel,
  output logic [7:0] pcValue,
  output logic [7:0] memAddr,
  output logic       addrValid,
  output logic       addrConflict
);

  localparam int ADDR_W = 8;

  pcStrobes_t strobes;

  pcAddrCtrl ctrl_i (
    .nextSel (nextSel),
    .pcEn    (pcEn),
    .addrSel (addrSel),
    .strobes (strobes)
  );

  pcAddrDatapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk          (clk),
    .rst          (rst),
    .irAddr       (irAddr),
    .strobes      (strobes),
    .pcValue      (pcValue),
    .memAddr      (memAddr),
    .addrValid    (addrValid),
    .addrConflict (addrConflict)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> pcValue == '0);

  p_dead_codes_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pcEn && nextSel[1]) |=> $stable(pcValue));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !pcEn |=> $stable(pcValue));

  p_ir_on_bus_r6: assert property (@(posedge clk) disable iff (rst)
    (addrSel == 2'b01) |-> (addrValid && memAddr == irAddr));

  p_pc_on_bus_r7: assert property (@(posedge clk) disable iff (rst)
    (addrSel == 2'b10) |-> (addrValid && memAddr == pcValue));

  p_bus_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (addrSel == 2'b00) |-> (!addrValid && memAddr == '0));

  p_bus_clash_r9: assert property (@(posedge clk) disable iff (rst)
    (addrSel == 2'b11) |-> (addrConflict && !addrValid && memAddr == '0));

  p_no_false_clash_r10: assert property (@(posedge clk) disable iff (rst)
    (addrSel != 2'b11) |-> !addrConflict);

endmodule

// File: tb/pcAddrTop_tb_top.sv
module pcAddrTop_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irAddr;
  logic [1:0] nextSel;
  logic       pcEn;
  logic [1:0] addrSel;
  logic [7:0] pcValue;
  logic [7:0] memAddr;
  logic       addrValid;
  logic       addrConflict;

  int checks = 0;
  int errors = 0;
  int refPc  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  pcAddrTop dut_i (
    .clk(clk), .rst(rst), .irAddr(irAddr), .nextSel(nextSel), .pcEn(pcEn),
    .addrSel(addrSel), .pcValue(pcValue), .memAddr(memAddr),
    .addrValid(addrValid), .addrConflict(addrConflict)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkBus(input logic [7:0] ir, input logic [1:0] as);
    int expA;
    int expV;
    int expC;
    string tag;
    case (as)
      2'b01:   begin expA = ir;    expV = 1; expC = 0; tag = "R6"; end
      2'b10:   begin expA = refPc; expV = 1; expC = 0; tag = "R7"; end
      2'b00:   begin expA = 0;     expV = 0; expC = 0; tag = "R8"; end
      default: begin expA = 0;     expV = 0; expC = 1; tag = "R9"; end
    endcase
    chk(memAddr == expA[7:0], {tag, " memAddr"}, memAddr, expA);
    chk(addrValid == expV[0], {tag, " addrValid"}, addrValid, expV);
    chk(addrConflict == expC[0], (as == 2'b11) ? "R9 addrConflict" : "R10 addrConflict",
        addrConflict, expC);
  endtask

  // one cycle: drive after the falling edge, check bus, clock, check count
  task automatic step(input logic r, input logic [7:0] ir, input logic [1:0] ns,
                      input logic en, input logic [1:0] as);
    string tag;
    rst = r; irAddr = ir; nextSel = ns; pcEn = en; addrSel = as;
    #1;
    checkBus(ir, as);
    @(posedge clk);
    if (r) begin refPc = 0; tag = "R1"; end
    else if (!en) tag = "R5";
    else if (ns == 2'b00) begin refPc = ir; tag = "R2"; end
    else if (ns == 2'b01) begin refPc = (refPc + 1) % 256; tag = "R3"; end
    else tag = "R4";
    @(negedge clk);
    chk(pcValue == refPc[7:0], {tag, " pcValue"}, pcValue, refPc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; irAddr = '0; nextSel = '0; pcEn = 1'b0; addrSel = 2'b00;
    @(negedge clk);
    step(1'b1, 8'h5A, 2'b00, 1'b1, 2'b00);      // R1 reset despite load request
    step(1'b0, 8'hFE, 2'b00, 1'b1, 2'b01);      // R2 jump, R6 bus
    step(1'b0, 8'h11, 2'b01, 1'b1, 2'b10);      // R3 -> FF, R7 bus
    step(1'b0, 8'h22, 2'b01, 1'b1, 2'b10);      // R3 wrap -> 00
    step(1'b0, 8'h33, 2'b01, 1'b1, 2'b00);      // R3 -> 01, R8
    step(1'b0, 8'h44, 2'b10, 1'b1, 2'b11);      // R4 hold, R9
    step(1'b0, 8'h55, 2'b11, 1'b1, 2'b10);      // R4 hold
    for (int c = 0; c < 4; c++)
      step(1'b0, 8'hC3, 2'(c), 1'b0, 2'(c));    // R5 hold for all codes
    step(1'b0, 8'h0F, 2'b00, 1'b1, 2'b10);      // R2 jump
    step(1'b1, 8'h77, 2'b01, 1'b1, 2'b01);      // R1 reset mid-run
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step((i == 200), lfsr[7:0], lfsr[9:8], lfsr[10] | lfsr[11], lfsr[13:12]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule